// File: doc/BRIEF.md
# Masked Test-Port Configuration Writer

This block owns a 16-bit control register whose fields drive a narrow sideband test port: a 6-bit register address, a 4-bit data nibble and a write strobe. Every update of the register arrives as a 32-bit word. The upper half of the word is a per-bit write enable for the lower half, so a writer can change one field without touching the others and without reading first.

Two agents can update the register. The first is a simple bus, which writes masked words directly and can read the register back. The second is an internal sequencer, started by a request/acknowledge handshake, which performs a complete test-port write in three steps. The first step loads address and data with the strobe held low. After a programmed gap the strobe is raised. After a second equal gap the strobe is lowered again, and the address and data stay as they are. The sequencer has priority. A bus write that arrives while a request is pending or a sequence is running is held off until the sequence has finished.

Top module: `tpcfg_writer`

## Requirements
- R1: On every applied write word W, register bit n (0..15) takes W[n] when W[n+16] is 1 and keeps its previous value when W[n+16] is 0. Without an applied write the register does not change.
- R2: The test-port outputs are taken from fixed register positions. The strobe is bit 0 (enable bit 16), the address is bits 6:1 (enables 22:17) and the data is bits 10:7 (enables 26:23). Bits 15:11 are plain storage (enables 31:27).
- R3: After reset the register is zero. The read-back port always returns the register in bits 15:0 and zero in bits 31:16.
- R4: When a request is accepted, the first register update loads the requested address and data and forces the strobe to 0. The strobe then stays low for exactly GAP_CYCLES cycles, is high for exactly GAP_CYCLES cycles, and is then cleared.
- R5: Neither the rising nor the falling edge of the sequencer's strobe pulse changes the address or data fields.
- R6: cfg_ack is a single-cycle pulse. It is asserted in the first cycle in which the strobe is back at 0 after the pulse, and it is never high while the strobe is high.
- R7: bus_wr_ready is low while cfg_req is high or a sequence is in progress. A bus write presented while bus_wr_ready is low has no effect on the register until it is accepted after the sequence ends.
- R8: A bus write whose enables cover only the address field changes the address. It leaves the data unchanged and produces no strobe.
- R9: The sequence never alters bits 15:11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr_en | input | 1 | Bus write request, held until accepted |
| bus_wr_data | input | 32 | Bus write word: enables in 31:16, values in 15:0 |
| bus_wr_ready | output | 1 | High when a bus write is accepted this cycle |
| bus_rd_data | output | 32 | Register read-back, upper half zero |
| cfg_req | input | 1 | Request a sequenced test-port write |
| cfg_addr | input | 6 | Test-port register address for the request |
| cfg_data | input | 4 | Test-port data for the request |
| cfg_ack | output | 1 | One-cycle completion pulse |
| tp_addr | output | 6 | Test-port address field |
| tp_data | output | 4 | Test-port data field |
| tp_strobe | output | 1 | Test-port write strobe |

## Verification
The bench builds the block with GAP_CYCLES set to 4, so that one sequence takes only a dozen cycles. At that size every one of the 64 × 16 address/data pairs can be sent through a full sequence, with the strobe, the acknowledge and the ready checked on every cycle. Each enable bit is also swept singly in both polarities, followed by a long run of pseudo-random masked words compared against an arithmetic model of the register. Stall and address-only behaviour are tested against the same model.

// File: rtl/tpcfg_pkg.sv
package tpcfg_pkg;

    localparam int REG_W   = 16;
    localparam int WORD_W  = 2 * REG_W;
    localparam int STB_BIT = 0;
    localparam int ADDR_LO = 1;
    localparam int ADDR_W  = 6;
    localparam int DATA_LO = 7;
    localparam int DATA_W  = 4;

    localparam logic [REG_W-1:0] STB_MASK  = REG_W'(32'd1 << STB_BIT);
    localparam logic [REG_W-1:0] ADDR_MASK = REG_W'(((32'd1 << ADDR_W) - 32'd1) << ADDR_LO);
    localparam logic [REG_W-1:0] DATA_MASK = REG_W'(((32'd1 << DATA_W) - 32'd1) << DATA_LO);

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_PULSE,
        SQ_DONE
    } seq_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic              strobe;
    } tp_fields_t;

    function automatic tp_fields_t unpack_fields(input logic [REG_W-1:0] r);
        tp_fields_t f;
        f.addr   = r[ADDR_LO +: ADDR_W];
        f.data   = r[DATA_LO +: DATA_W];
        f.strobe = r[STB_BIT];
        return f;
    endfunction

    function automatic logic [REG_W-1:0] place_fields(input logic [ADDR_W-1:0] a,
                                                      input logic [DATA_W-1:0] d,
                                                      input logic              s);
        logic [REG_W-1:0] v;
        v = '0;
        v[ADDR_LO +: ADDR_W] = a;
        v[DATA_LO +: DATA_W] = d;
        v[STB_BIT]           = s;
        return v;
    endfunction

    function automatic logic [WORD_W-1:0] masked_word(input logic [REG_W-1:0] en,
                                                      input logic [REG_W-1:0] val);
        return {en, val & en};
    endfunction

endpackage

// File: rtl/tpcfg_masked_reg.sv
module tpcfg_masked_reg #(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [2*WIDTH-1:0] wr_word,
    output logic [WIDTH-1:0]   q
);

    logic [WIDTH-1:0] nxt;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            assign nxt[i] = (wr_en && wr_word[WIDTH+i]) ? wr_word[i] : q[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

    AST_UNMASKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((q ^ $past(q)) & ~$past(wr_word[2*WIDTH-1:WIDTH])) == '0); // R1

    AST_NO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(q)); // R1

endmodule

// File: rtl/tpcfg_gap_timer.sv
module tpcfg_gap_timer #(
    parameter int GAP_CYCLES = 100
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic expired
);

    localparam int CW = $clog2(GAP_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(GAP_CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr)        cnt <= '0;
        else if (cnt != LAST)  cnt <= cnt + 1'b1;
    end

    assign expired = (cnt == LAST);

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!clr && !expired) |=> (cnt == $past(cnt) + 1'b1)); // R4

endmodule

// File: rtl/tpcfg_sequencer.sv
module tpcfg_sequencer
    import tpcfg_pkg::*;
#(
    parameter int GAP_CYCLES = 100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    output logic              busy,
    output logic              ack,
    output logic              we,
    output logic [WORD_W-1:0] word
);

    seq_state_t state, nxt_state;
    logic       expired;
    logic       tmr_clr;

    assign tmr_clr = (state == SQ_IDLE) || (state == SQ_SETUP && expired);

    tpcfg_gap_timer #(.GAP_CYCLES(GAP_CYCLES)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clr     (tmr_clr),
        .expired (expired)
    );

    always_comb begin
        nxt_state = state;
        we        = 1'b0;
        word      = '0;
        unique case (state)
            SQ_IDLE: if (req) begin
                we        = 1'b1;
                word      = masked_word(ADDR_MASK | DATA_MASK | STB_MASK,
                                        place_fields(req_addr, req_data, 1'b0));
                nxt_state = SQ_SETUP;
            end
            SQ_SETUP: if (expired) begin
                we        = 1'b1;
                word      = masked_word(STB_MASK, STB_MASK);
                nxt_state = SQ_PULSE;
            end
            SQ_PULSE: if (expired) begin
                we        = 1'b1;
                word      = masked_word(STB_MASK, '0);
                nxt_state = SQ_DONE;
            end
            SQ_DONE: nxt_state = SQ_IDLE;
            default: nxt_state = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SQ_IDLE;
        else     state <= nxt_state;
    end

    assign busy = (state != SQ_IDLE) || req;
    assign ack  = (state == SQ_DONE);

    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        ack |=> !ack); // R6

    AST_PULSE_ORDER: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_PULSE) |-> ($past(state) == SQ_SETUP || $past(state) == SQ_PULSE)); // R4

endmodule

// File: rtl/tpcfg_writer.sv
module tpcfg_writer
    import tpcfg_pkg::*;
#(
    parameter int GAP_CYCLES = 100
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr_en,
    input  logic [31:0] bus_wr_data,
    output logic        bus_wr_ready,
    output logic [31:0] bus_rd_data,
    input  logic        cfg_req,
    input  logic [5:0]  cfg_addr,
    input  logic [3:0]  cfg_data,
    output logic        cfg_ack,
    output logic [5:0]  tp_addr,
    output logic [3:0]  tp_data,
    output logic        tp_strobe
);

    logic              seq_busy;
    logic              seq_we;
    logic [WORD_W-1:0] seq_word;
    logic              bus_accept;
    logic              reg_we;
    logic [WORD_W-1:0] reg_word;
    logic [REG_W-1:0]  reg_q;
    tp_fields_t        fields;

    tpcfg_sequencer #(.GAP_CYCLES(GAP_CYCLES)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .req      (cfg_req),
        .req_addr (cfg_addr),
        .req_data (cfg_data),
        .busy     (seq_busy),
        .ack      (cfg_ack),
        .we       (seq_we),
        .word     (seq_word)
    );

    assign bus_wr_ready = !seq_busy;
    assign bus_accept   = bus_wr_en && bus_wr_ready;
    assign reg_we       = seq_we || bus_accept;
    assign reg_word     = seq_we ? seq_word : bus_wr_data;

    tpcfg_masked_reg #(.WIDTH(REG_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (reg_we),
        .wr_word (reg_word),
        .q       (reg_q)
    );

    assign fields      = unpack_fields(reg_q);
    assign tp_addr     = fields.addr;
    assign tp_data     = fields.data;
    assign tp_strobe   = fields.strobe;
    assign bus_rd_data = {{(32-REG_W){1'b0}}, reg_q};

    AST_ACK_STROBE_LOW: assert property (@(posedge clk) disable iff (rst)
        cfg_ack |-> !tp_strobe); // R6

    AST_RISE_FIELDS_STABLE: assert property (@(posedge clk) disable iff (rst)
        ($rose(tp_strobe) && $past(seq_busy)) |-> $stable({tp_addr, tp_data})); // R5

    AST_FALL_FIELDS_STABLE: assert property (@(posedge clk) disable iff (rst)
        ($fell(tp_strobe) && cfg_ack) |-> $stable({tp_addr, tp_data})); // R5

    AST_STALL_AT_ACK: assert property (@(posedge clk) disable iff (rst)
        cfg_ack |-> !bus_wr_ready); // R7

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        bus_rd_data[31:16] == 16'h0); // R3

endmodule

// File: tb/tpcfg_writer_test.sv
module tpcfg_writer_test;

    localparam int GAP = 4;

    logic        clk = 1'b0;
    logic        rst;
    logic        bus_wr_en;
    logic [31:0] bus_wr_data;
    logic        bus_wr_ready;
    logic [31:0] bus_rd_data;
    logic        cfg_req;
    logic [5:0]  cfg_addr;
    logic [3:0]  cfg_data;
    logic        cfg_ack;
    logic [5:0]  tp_addr;
    logic [3:0]  tp_data;
    logic        tp_strobe;

    int          checks = 0;
    int          errors = 0;
    logic [15:0] model;

    always #5 clk = ~clk;

    tpcfg_writer #(.GAP_CYCLES(GAP)) uut (
        .clk (clk), .rst (rst),
        .bus_wr_en (bus_wr_en), .bus_wr_data (bus_wr_data),
        .bus_wr_ready (bus_wr_ready), .bus_rd_data (bus_rd_data),
        .cfg_req (cfg_req), .cfg_addr (cfg_addr), .cfg_data (cfg_data),
        .cfg_ack (cfg_ack),
        .tp_addr (tp_addr), .tp_data (tp_data), .tp_strobe (tp_strobe)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [31:0] w);
        @(negedge clk);
        bus_wr_en   = 1'b1;
        bus_wr_data = w;
        while (!bus_wr_ready) @(negedge clk);
        @(posedge clk);
        #1 bus_wr_en = 1'b0;
        model = (model & ~w[31:16]) | (w[15:0] & w[31:16]);
    endtask

    task automatic check_regs(input string tag);
        @(negedge clk);
        check(tag, bus_rd_data, {16'h0, model});
        check(tag, {26'h0, tp_addr}, {26'h0, model[6:1]});
        check(tag, {28'h0, tp_data}, {28'h0, model[10:7]});
        check(tag, {31'h0, tp_strobe}, {31'h0, model[0]});
    endtask

    task automatic run_cfg(input logic [5:0] a, input logic [3:0] d);
        logic [4:0] hi;
        @(negedge clk);
        hi       = model[15:11];
        cfg_req  = 1'b1;
        cfg_addr = a;
        cfg_data = d;
        #1 check("R7 ready low on request", {31'h0, bus_wr_ready}, 32'h0);
        for (int k = 1; k <= 2 * GAP + 1; k++) begin
            @(negedge clk);
            check("R4 strobe", {31'h0, tp_strobe}, {31'h0, (k > GAP && k <= 2 * GAP)});
            check("R6 ack", {31'h0, cfg_ack}, {31'h0, (k == 2 * GAP + 1)});
            check("R5 fields", {22'h0, tp_addr, tp_data}, {22'h0, a, d});
            check("R7 ready", {31'h0, bus_wr_ready}, 32'h0);
            check("R9 upper bits", {27'h0, bus_rd_data[15:11]}, {27'h0, hi});
            if (k == 2 * GAP + 1) cfg_req = 1'b0;
        end
        @(negedge clk);
        check("R6 ack drop", {31'h0, cfg_ack}, 32'h0);
        check("R7 ready back", {31'h0, bus_wr_ready}, 32'h1);
        model = (model & ~16'h07FF) | {5'h0, d, a, 1'b0};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lf;
        rst         = 1'b1;
        bus_wr_en   = 1'b0;
        bus_wr_data = '0;
        cfg_req     = 1'b0;
        cfg_addr    = '0;
        cfg_data    = '0;
        model       = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;

        // R3 reset state
        check_regs("R3 reset");
        check("R3 ack idle", {31'h0, cfg_ack}, 32'h0);
        check("R3 ready idle", {31'h0, bus_wr_ready}, 32'h1);

        // R1 and R2: every enable bit alone, both polarities
        for (int n = 0; n < 16; n++) begin
            bus_write((32'h1 << (n + 16)) | (32'h1 << n) | 32'h0000_FFFF);
            check_regs("R1 single enable set");
            bus_write(32'h1 << (n + 16));
            check_regs("R2 single enable clear");
        end

        // R1: pseudo-random words, values present on unmasked bits too
        lf = 32'hACE1_2345;
        for (int i = 0; i < 300; i++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            bus_write(lf);
            check_regs("R1 random masked write");
        end

        // R4..R6: full address/data sweep through the sequencer
        bus_write(32'hF800_5000);
        for (int a = 0; a < 64; a++) begin
            for (int d = 0; d < 16; d++) begin
                run_cfg(6'(a), 4'(d));
            end
        end
        check_regs("R9 after sweep");

        // R7: bus write presented during a sequence is stalled
        fork
            run_cfg(6'h2A, 4'h5);
            begin
                @(negedge clk);
                @(negedge clk);
                bus_write(32'h8001_8001);
            end
        join
        check_regs("R7 stalled write lands after");
        bus_write(32'h0001_0000);
        check_regs("R7 strobe cleared");

        // R8: address-only write
        run_cfg(6'h11, 4'hC);
        bus_write(32'h007E_0000 | (32'h33 << 1));
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 no strobe", {31'h0, tp_strobe}, 32'h0);
            check("R8 data kept", {28'h0, tp_data}, 32'hC);
            check("R8 address", {26'h0, tp_addr}, 32'h33);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule